// File: doc/BRIEF.md
# Iterative Eight-Point Radix-2 FFT Kernel

This block computes an eight-point complex discrete Fourier transform with a single radix-2 butterfly that is reused for every operation of the transform. A parent block arms it with a one-cycle `start` pulse and then streams eight complex samples in through a valid/ready input. Each sample is written into a small two-port working memory at the bit-reversed position of its arrival index. The transform then runs three decimation-in-time stages of four butterflies each, one butterfly per clock cycle. An address generator supplies the operand pair and the twiddle index, and a coefficient table supplies cos and -sin in Q1.15.

Every butterfly output is halved, so the results equal the true DFT divided by eight. They leave through a valid/ready output in natural frequency order, and the eighth result carries a last flag. `busy` and `done` let the parent sequence the kernel without watching the data streams.

Samples are 16-bit signed real plus 16-bit signed imaginary. For the halving to be sufficient, input magnitudes should stay below about half of full scale.

Top module: `fft8_core`

## Requirements
- R1: While reset is asserted and directly after it, `in_ready`, `out_valid`, `out_last`, `busy` and `done` are all 0.
- R2: In the idle state `in_ready` is 0, and samples offered there are not taken. The cycle after a `start` pulse, `in_ready` is 1.
- R3: `busy` is 0 until the first sample is accepted. It is 1 from the next cycle until the eighth result is accepted. `done` is then 1 for exactly one cycle, with `busy` 0.
- R4: From the cycle after the eighth sample is accepted until the next `start`, `in_ready` is 0.
- R5: Results appear in natural order X[0] to X[7], and `out_last` is 1 only with X[7].
- R6: Result X[k] equals (1/8)·Σ x[n]·e^(-j2πnk/8) over n = 0..7, within ±6 LSB on each of the real and imaginary parts.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_re`, `out_im` and `out_last` hold their values.
- R8: `out_valid` first rises 12 clock cycles after the edge that accepts the eighth sample, one cycle per butterfly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arms the kernel for a new load when idle |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Kernel accepts a sample |
| in_re | input | 16 | Input sample, real part |
| in_im | input | 16 | Input sample, imaginary part |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts a result |
| out_re | output | 16 | Result, real part |
| out_im | output | 16 | Result, imaginary part |
| out_last | output | 1 | Marks the eighth result |
| busy | output | 1 | A transform is in progress |
| done | output | 1 | One-cycle pulse after the last result is taken |

## Verification
The bench targets operand pairing and twiddle selection in each stage. A wrong address or twiddle index leaves the impulse and DC cases correct but corrupts the mixed-sign vector and the complex-input case. Bit-reversed loading is checked through output order: a design that skipped the reversal would emit the right values in scrambled positions. Output back-pressure is applied between every result to expose a design that advances its read pointer or changes data without a handshake. Samples offered before `start`, and the idle gap after `done`, would expose a kernel that accepted input it should have refused.

// File: rtl/fft8_pkg.sv
package fft8_pkg;
  localparam int unsigned POINTS  = 8;
  localparam int unsigned LOG2N   = $clog2(POINTS);
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned TW_W    = 16;
  localparam int unsigned ADDR_W  = LOG2N;
  localparam int unsigned HALF_N  = POINTS / 2;
  localparam int unsigned BF_W    = $clog2(HALF_N);
  localparam int unsigned STG_W   = (LOG2N > 1) ? $clog2(LOG2N) : 1;

  typedef struct packed {
    logic signed [DATA_W-1:0] re;
    logic signed [DATA_W-1:0] im;
  } cplx_t;

  typedef struct packed {
    logic signed [TW_W-1:0] c;
    logic signed [TW_W-1:0] s;
  } twid_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_CALC  = 2'd2,
    ST_DRAIN = 2'd3
  } fsm_t;

  function automatic logic [ADDR_W-1:0] bit_rev(input logic [ADDR_W-1:0] v);
    logic [ADDR_W-1:0] r;
    for (int i = 0; i < ADDR_W; i++) r[i] = v[ADDR_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/fft8_twiddle_rom.sv
module fft8_twiddle_rom
  import fft8_pkg::*;
(
  input  logic [BF_W-1:0] k,
  output twid_t           w
);
  localparam int ONE  = (1 << (TW_W - 1)) - 1;
  localparam int RT2  = (ONE * 46341) >>> 16;

  // W8^k = cos(2*pi*k/8) - j sin(2*pi*k/8); table holds cos and -sin
  always_comb begin
    unique case (k)
      2'd0:    begin w.c = TW_W'(ONE);   w.s = '0;            end
      2'd1:    begin w.c = TW_W'(RT2);   w.s = TW_W'(-RT2);   end
      2'd2:    begin w.c = '0;           w.s = TW_W'(-ONE);   end
      default: begin w.c = TW_W'(-RT2);  w.s = TW_W'(-RT2);   end
    endcase
  end
endmodule

// File: rtl/fft8_agu.sv
module fft8_agu
  import fft8_pkg::*;
(
  input  logic [STG_W-1:0]  stage,
  input  logic [BF_W-1:0]   bf,
  output logic [ADDR_W-1:0] addr_a,
  output logic [ADDR_W-1:0] addr_b,
  output logic [BF_W-1:0]   tw_k
);
  int unsigned half, pos, grp, top, bot, kk;

  always_comb begin
    half   = 1 << stage;
    pos    = int'(bf) & (half - 1);
    grp    = int'(bf) >> stage;
    top    = (grp << (stage + 1)) | pos;
    bot    = top + half;
    kk     = pos << (LOG2N - 1 - int'(stage));
    addr_a = ADDR_W'(top);
    addr_b = ADDR_W'(bot);
    tw_k   = BF_W'(kk);
  end
endmodule

// File: rtl/fft8_butterfly.sv
module fft8_butterfly
  import fft8_pkg::*;
(
  input  cplx_t a,
  input  cplx_t b,
  input  twid_t w,
  output cplx_t y0,
  output cplx_t y1
);
  localparam int PW = DATA_W + TW_W + 1;
  localparam int SW = DATA_W + 2;

  logic signed [PW-1:0] pr, pi, pr_s, pi_s;
  logic signed [SW-1:0] t_re, t_im, s0_re, s0_im, s1_re, s1_im;

  always_comb begin
    pr    = PW'(b.re) * PW'(w.c) - PW'(b.im) * PW'(w.s);
    pi    = PW'(b.re) * PW'(w.s) + PW'(b.im) * PW'(w.c);
    pr_s  = pr >>> (TW_W - 1);
    pi_s  = pi >>> (TW_W - 1);
    t_re  = pr_s[SW-1:0];
    t_im  = pi_s[SW-1:0];
    s0_re = SW'(a.re) + t_re;
    s0_im = SW'(a.im) + t_im;
    s1_re = SW'(a.re) - t_re;
    s1_im = SW'(a.im) - t_im;
    // halve every stage output
    y0.re = s0_re[DATA_W:1];
    y0.im = s0_im[DATA_W:1];
    y1.re = s1_re[DATA_W:1];
    y1.im = s1_im[DATA_W:1];
  end
endmodule

// File: rtl/fft8_ram.sv
module fft8_ram
  import fft8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_we,
  input  cplx_t             a_wdata,
  output cplx_t             a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_we,
  input  cplx_t             b_wdata,
  output cplx_t             b_rdata
);
  cplx_t mem [POINTS];

  assign a_rdata = mem[a_addr];
  assign b_rdata = mem[b_addr];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
  end

  // R6: a butterfly must never write both results to one word
  p_port_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we && b_we) |-> (a_addr != b_addr));
endmodule

// File: rtl/fft8_core.sv
module fft8_core
  import fft8_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_re,
  input  logic signed [DATA_W-1:0] in_im,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_re,
  output logic signed [DATA_W-1:0] out_im,
  output logic                     out_last,
  output logic                     busy,
  output logic                     done
);
  localparam logic [ADDR_W-1:0] CNT_LAST = ADDR_W'(POINTS - 1);
  localparam logic [BF_W-1:0]   BF_LAST  = BF_W'(HALF_N - 1);
  localparam logic [STG_W-1:0]  STG_LAST = STG_W'(LOG2N - 1);

  fsm_t              state_q, state_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic [STG_W-1:0]  stg_q, stg_d;
  logic [BF_W-1:0]   bf_q, bf_d;
  logic              done_q, done_d;

  logic in_fire, out_fire;
  logic [ADDR_W-1:0] agu_a, agu_b;
  logic [BF_W-1:0]   tw_k;
  twid_t             tw;
  cplx_t             rd_a, rd_b, bf_y0, bf_y1, wr_a, in_s;
  logic [ADDR_W-1:0] ram_a_addr;
  logic              ram_a_we, ram_b_we;

  assign in_ready  = (state_q == ST_LOAD);
  assign out_valid = (state_q == ST_DRAIN);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign busy      = ((state_q == ST_LOAD) && (cnt_q != '0)) ||
                     (state_q == ST_CALC) || (state_q == ST_DRAIN);
  assign done      = done_q;
  assign out_last  = out_valid && (cnt_q == CNT_LAST);
  assign out_re    = rd_a.re;
  assign out_im    = rd_a.im;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    stg_d   = stg_q;
    bf_d    = bf_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_LOAD;
          cnt_d   = '0;
        end
      end
      ST_LOAD: begin
        if (in_fire) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) begin
            state_d = ST_CALC;
            stg_d   = '0;
            bf_d    = '0;
          end
        end
      end
      ST_CALC: begin
        bf_d = bf_q + 1'b1;
        if (bf_q == BF_LAST) begin
          stg_d = stg_q + 1'b1;
          if (stg_q == STG_LAST) begin
            state_d = ST_DRAIN;
            cnt_d   = '0;
          end
        end
      end
      default: begin
        if (out_fire) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      stg_q   <= '0;
      bf_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      stg_q   <= stg_d;
      bf_q    <= bf_d;
      done_q  <= done_d;
    end
  end

  fft8_agu u_agu (
    .stage (stg_q),
    .bf    (bf_q),
    .addr_a(agu_a),
    .addr_b(agu_b),
    .tw_k  (tw_k)
  );

  fft8_twiddle_rom u_rom (
    .k(tw_k),
    .w(tw)
  );

  fft8_butterfly u_bfly (
    .a (rd_a),
    .b (rd_b),
    .w (tw),
    .y0(bf_y0),
    .y1(bf_y1)
  );

  // port A: loading (bit-reversed), butterfly top operand, draining
  always_comb begin
    in_s.re = in_re;
    in_s.im = in_im;
    unique case (state_q)
      ST_LOAD: ram_a_addr = bit_rev(cnt_q);
      ST_CALC: ram_a_addr = agu_a;
      default: ram_a_addr = cnt_q;
    endcase
    ram_a_we = in_fire || (state_q == ST_CALC);
    wr_a     = (state_q == ST_CALC) ? bf_y0 : in_s;
    ram_b_we = (state_q == ST_CALC);
  end

  fft8_ram u_ram (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_addr (ram_a_addr),
    .a_we   (ram_a_we),
    .a_wdata(wr_a),
    .a_rdata(rd_a),
    .b_addr (agu_b),
    .b_we   (ram_b_we),
    .b_wdata(bf_y1),
    .b_rdata(rd_b)
  );

  // R4: no sample is taken while results are pending
  p_no_input_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  // R7: stalled result holds
  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) &&
                                   $stable(out_im) && $stable(out_last)));
  // R3: done is a single-cycle pulse with busy low
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !out_valid));
  // R5: last flag only on a valid result
  p_last_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  // R8: results only appear after the butterfly sequence
  p_drain_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(state_q) == ST_CALC));
  // R6: each butterfly touches two distinct words
  p_pair_distinct_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CALC) |-> (agu_a != agu_b));
endmodule

// File: tb/fft8_core_tb.sv
module fft8_core_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  TOL = 6;

  logic clk, rst_n, start, in_valid, in_ready, out_valid, out_ready;
  logic out_last, busy, done;
  logic signed [15:0] in_re, in_im, out_re, out_im;

  int checks = 0;
  int errors = 0;
  int xr[8];
  int xi[8];

  fft8_core dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_ready(out_ready), .out_re(out_re), .out_im(out_im),
    .out_last(out_last), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_near(input string req, input string what, input int act, input int exp);
    checks++;
    if (act > exp + TOL || act < exp - TOL) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 0; in_valid = 0; in_re = 0; in_im = 0; out_ready = 0;
    #(CLK_PERIOD*3);
    check("R1", "in_ready in reset", int'(in_ready), 0);
    check("R1", "out_valid in reset", int'(out_valid), 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R1", "busy after reset", int'(busy), 0);
    check("R1", "done after reset", int'(done), 0);
    check("R1", "out_last after reset", int'(out_last), 0);
  endtask

  // offer junk while idle; R2 says it must be refused
  task automatic t_idle_refuse();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1; in_re = 16'sd7777; in_im = -16'sd5555;
      check("R2", "in_ready while idle", int'(in_ready), 0);
    end
    @(negedge clk) in_valid = 0;
  endtask

  task automatic run(input string name, input bit stall);
    real ar, ai, ph;
    int er, ei, lat, gr, gi;
    $display("scenario %s", name);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    check("R2", {name, " in_ready after start"}, int'(in_ready), 1);
    check("R3", {name, " busy before first sample"}, int'(busy), 0);
    for (int n = 0; n < 8; n++) begin
      in_valid = 1; in_re = 16'(xr[n]); in_im = 16'(xi[n]);
      @(negedge clk);
      check("R3", {name, " busy after sample"}, int'(busy), 1);
    end
    in_valid = 0;
    // eighth sample was taken at the previous posedge
    lat = 0;
    do begin
      check("R4", {name, " in_ready while computing"}, int'(in_ready), 0);
      @(posedge clk); lat++;
      @(negedge clk);
    end while (!out_valid && lat < 40);
    check("R8", {name, " latency"}, lat, 12);
    out_ready = !stall;
    for (int k = 0; k < 8; k++) begin
      ar = 0.0; ai = 0.0;
      for (int n = 0; n < 8; n++) begin
        ph = 2.0 * 3.14159265358979 * n * k / 8.0;
        ar += xr[n] * $cos(ph) + xi[n] * $sin(ph);
        ai += xi[n] * $cos(ph) - xr[n] * $sin(ph);
      end
      er = $rtoi(ar / 8.0 + ((ar >= 0.0) ? 0.5 : -0.5));
      ei = $rtoi(ai / 8.0 + ((ai >= 0.0) ? 0.5 : -0.5));
      check("R5", {name, " out_valid"}, int'(out_valid), 1);
      check("R4", {name, " in_ready while draining"}, int'(in_ready), 0);
      check("R5", {name, " out_last"}, int'(out_last), (k == 7) ? 1 : 0);
      gr = int'(out_re); gi = int'(out_im);
      check_near("R6", $sformatf("%s X[%0d] re", name, k), gr, er);
      check_near("R6", $sformatf("%s X[%0d] im", name, k), gi, ei);
      if (stall) begin
        out_ready = 0;
        @(negedge clk);
        check("R7", {name, " valid held"}, int'(out_valid), 1);
        check("R7", {name, " re held"}, int'(out_re), gr);
        check("R7", {name, " im held"}, int'(out_im), gi);
        @(negedge clk);
        check("R7", {name, " re held 2"}, int'(out_re), gr);
        out_ready = 1;
      end
      @(negedge clk);
    end
    out_ready = 0;
    check("R3", {name, " done pulse"}, int'(done), 1);
    check("R3", {name, " busy at done"}, int'(busy), 0);
    check("R5", {name, " out_valid after last"}, int'(out_valid), 0);
    @(negedge clk);
    check("R3", {name, " done one cycle"}, int'(done), 0);
    check("R4", {name, " in_ready idle after done"}, int'(in_ready), 0);
  endtask

  task automatic t_vector();
    int v[8] = '{4096, -4096, 2048, -12288, 8192, -10240, 0, 16384};
    for (int n = 0; n < 8; n++) begin xr[n] = v[n]; xi[n] = 0; end
    run("mixed-sign vector", 0);
  endtask

  task automatic t_impulse();
    for (int n = 0; n < 8; n++) begin xr[n] = (n == 0) ? 8000 : 0; xi[n] = 0; end
    run("impulse", 0);
  endtask

  task automatic t_dc();
    for (int n = 0; n < 8; n++) begin xr[n] = 800; xi[n] = -400; end
    run("dc", 0);
  endtask

  task automatic t_complex_stall();
    int a[8] = '{3000, -1200, 500, 7000, -6000, 2500, -300, 1100};
    int b[8] = '{-2000, 4000, 900, -3500, 1500, 0, 6200, -800};
    for (int n = 0; n < 8; n++) begin xr[n] = a[n]; xi[n] = b[n]; end
    run("complex with back-pressure", 1);
  endtask

  task automatic t_tone();
    for (int n = 0; n < 8; n++) begin
      xr[n] = $rtoi(6000.0 * $cos(2.0 * 3.14159265358979 * 3 * n / 8.0));
      xi[n] = $rtoi(6000.0 * $sin(2.0 * 3.14159265358979 * 3 * n / 8.0));
    end
    run("tone bin 3", 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_idle_refuse();
    t_vector();
    t_impulse();
    t_dc();
    t_complex_stall();
    t_tone();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule